// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with High/Low Result Pair

This block performs integer multiplication and division for a processor pipeline. Each operation runs one bit per cycle. A command carries two operands and a two-bit operation code. The block then raises `busy` and, after a fixed number of iterations, writes its result into a dedicated pair of result registers, called high and low, instead of writing to the general register file.

A multiply leaves the double-width product split across the pair. A divide leaves the quotient in low and the remainder in high. Both have signed (two's-complement) and unsigned forms, and none of them signals overflow. The pipeline copies either register out through a small read port. That port reports itself not ready while a computation is in flight, so the read interlock is the only stall the surrounding pipeline has to honour.

Operation codes: 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide. The read select is 0 for low and 1 for high.

Top module: `mdu_hilo`

## Requirements
- R1: After synchronous reset, `busy` is 0, `rd_ready` is 1, `rd_data` is 0, and both the high and low registers read as 0.
- R2: Operation code 0 (signed multiply) treats both operands as two's-complement numbers. It leaves bits [2W-1:W] of the 2W-bit product in high and bits [W-1:0] in low.
- R3: Operation code 1 (unsigned multiply) treats both operands as natural numbers and splits the 2W-bit product in the same way as R2.
- R4: Operation code 2 (signed divide) writes the quotient, truncated toward zero, to low, wrapped to W bits. It writes the remainder, which carries the sign of the dividend, to high.
- R5: Operation code 3 (unsigned divide) writes the natural-number quotient to low and the remainder to high.
- R6: A start accepted while idle raises `busy` in the next cycle. `busy` then stays high for exactly W cycles, and high and low change only on the clock edge where `busy` falls.
- R7: A `start` presented while `busy` is high has no effect: the running operation keeps its operands, operation code and W-cycle duration.
- R8: A divide with a zero divisor completes in the same W cycles as any other operation and returns the unit to idle.
- R9: `rd_ready` is 0 while `busy` is high and 1 otherwise. `rd_data` holds its value while busy. A clock edge that sees `rd_req` and `rd_ready` both high loads `rd_data` with high when `rd_sel` is 1 and with low when `rd_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command, accepted when idle |
| op | input | 2 | Operation code (see R2 to R5) |
| opnd_a | input | W | Multiplicand or dividend |
| opnd_b | input | W | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| rd_req | input | 1 | Request to copy a result register |
| rd_sel | input | 1 | 0 selects low, 1 selects high |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_data | output | W | Registered read result |

## Verification
On every cycle the assertions check the timing contract. They confirm that `busy` lasts exactly W cycles, that it cannot be cut short by a second start, that high and low change only when an operation retires, that the read port stalls while busy, and that a read returns the register it selected. The arithmetic itself is not checked by the assertions: the product, quotient and remainder values, the truncation toward zero, the sign of the remainder and the wrap of the most-negative quotient are shown only by the bench. It sweeps every operand pair and every operation code at W = 4. Directed scenarios cover a start issued during busy, and a read held through a whole computation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } mdu_op_e;

  function automatic logic op_is_div(input mdu_op_e o);
    return o[1];
  endfunction

  function automatic logic op_is_signed(input mdu_op_e o);
    return ~o[0];
  endfunction
endpackage

// File: rtl/mdu_negate.sv
module mdu_negate #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val,
  input  logic             neg,
  output logic [WIDTH-1:0] res
);
  assign res = neg ? (-val) : val;
endmodule

// File: rtl/mdu_mul_step.sv
// One shift-add step: accumulator holds {partial_upper, remaining_multiplier}.
module mdu_mul_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   mcand,
  output logic [2*W-1:0] acc_nxt
);
  logic [W:0] sum;
  always_comb begin
    sum     = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
    acc_nxt = {sum, acc[W-1:1]};
  end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring step: accumulator holds {partial_remainder, dividend/quotient bits}.
module mdu_div_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   dvsr,
  output logic [2*W-1:0] acc_nxt
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;
  always_comb begin
    trial   = acc[2*W-1:W-1];
    diff    = trial - {1'b0, dvsr};
    fits    = ~diff[W];
    acc_nxt = {(fits ? diff[W-1:0] : trial[W-1:0]), acc[W-2:0], fits};
  end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IT = CW'(W - 1);

  mdu_op_e         op_in;
  logic            a_neg, b_neg;
  logic [W-1:0]    mag_a, mag_b;

  logic            busy_q;
  logic [CW-1:0]   cnt_q;
  mdu_op_e         op_q;
  logic            neg_lo_q, neg_hi_q;
  logic [W-1:0]    dvsr_q;
  logic [AW-1:0]   acc_q;
  logic [W-1:0]    hi_q, lo_q, rd_data_q;

  logic [AW-1:0]   mul_nxt, div_nxt, acc_nxt;
  logic [AW-1:0]   prod_fix;
  logic [W-1:0]    quot_fix, rem_fix;
  logic            last_it;

  assign op_in = mdu_op_e'(op);
  assign a_neg = op_is_signed(op_in) & opnd_a[W-1];
  assign b_neg = op_is_signed(op_in) & opnd_b[W-1];

  mdu_negate #(.WIDTH(W)) u_mag_a (.val(opnd_a), .neg(a_neg), .res(mag_a));
  mdu_negate #(.WIDTH(W)) u_mag_b (.val(opnd_b), .neg(b_neg), .res(mag_b));

  mdu_mul_step #(.W(W)) u_mul (.acc(acc_q), .mcand(dvsr_q), .acc_nxt(mul_nxt));
  mdu_div_step #(.W(W)) u_div (.acc(acc_q), .dvsr(dvsr_q),  .acc_nxt(div_nxt));

  assign acc_nxt = op_is_div(op_q) ? div_nxt : mul_nxt;

  mdu_negate #(.WIDTH(AW)) u_fix_prod (.val(acc_nxt),          .neg(neg_lo_q), .res(prod_fix));
  mdu_negate #(.WIDTH(W))  u_fix_quot (.val(acc_nxt[W-1:0]),   .neg(neg_lo_q), .res(quot_fix));
  mdu_negate #(.WIDTH(W))  u_fix_rem  (.val(acc_nxt[AW-1:W]),  .neg(neg_hi_q), .res(rem_fix));

  assign last_it = busy_q && (cnt_q == LAST_IT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_MUL_S;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
      dvsr_q   <= '0;
      acc_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        op_q     <= op_in;
        neg_lo_q <= a_neg ^ b_neg;
        neg_hi_q <= a_neg;
        dvsr_q   <= mag_b;
        acc_q    <= {{W{1'b0}}, mag_a};
      end
    end else begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (last_it) begin
        busy_q <= 1'b0;
        if (op_is_div(op_q)) begin
          lo_q <= quot_fix;
          hi_q <= rem_fix;
        end else begin
          lo_q <= prod_fix[W-1:0];
          hi_q <= prod_fix[AW-1:W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else if (rd_req && !busy_q) begin
      rd_data_q <= rd_sel ? hi_q : lo_q;
    end
  end

  assign busy     = busy_q;
  assign rd_ready = ~busy_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         rd_req,
  input logic         rd_sel,
  input logic         rd_ready,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int BCW = $clog2(W + 1) + 1;
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && hi_q == '0 && lo_q == '0));

  // R6
  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BCW'(W)));
  p_start_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  p_hilo_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(hi_q) && $stable(lo_q)));

  // R7
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && bcnt < BCW'(W - 1)) |=> busy);

  // R9
  p_read_stall_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_ready);
  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));
  p_read_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ready && !rd_sel) |=> (rd_data == $past(lo_q)));
  p_read_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ready && rd_sel) |=> (rd_data == $past(hi_q)));
endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .rd_req(rd_req), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/mdu_hilo_tb_top.sv
module mdu_hilo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int N  = 1 << BW;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [BW-1:0] opnd_a = '0, opnd_b = '0;
  logic          busy;
  logic          rd_req = 1'b0, rd_sel = 1'b0;
  logic          rd_ready;
  logic [BW-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_hilo #(.W(BW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= N/2) ? v - N : v;
  endfunction

  // Expected {hi, lo} from the requirement arithmetic
  function automatic void model(input int o, input int a, input int b,
                                output int eh, output int el);
    int p, q, r;
    case (o)
      0: begin p = sx(a) * sx(b); eh = (p >> BW) & (N-1); el = p & (N-1); end
      1: begin p = a * b;         eh = (p >> BW) & (N-1); el = p & (N-1); end
      2: begin q = sx(a) / sx(b); r = sx(a) % sx(b); eh = r & (N-1); el = q & (N-1); end
      default: begin eh = (a % b); el = (a / b); end
    endcase
  endfunction

  task automatic run_op(input int o, input int a, input int b, input bit disturb,
                        output int bcount);
    @(negedge clk);
    start = 1'b1; op = o[1:0]; opnd_a = a[BW-1:0]; opnd_b = b[BW-1:0];
    @(negedge clk);
    if (disturb) begin
      op = ~o[1:0]; opnd_a = ~a[BW-1:0]; opnd_b = b[BW-1:0] + 1'b1;
    end else begin
      start = 1'b0;
    end
    bcount = 0;
    while (busy && bcount < 4*BW) begin
      bcount++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic read_reg(input bit sel, output int val);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_req = 1'b0;
    val = int'(rd_data);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int v, h, l, eh, el, bc;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rd_ready == 1'b1, "R1 rd_ready", rd_ready, 1);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    read_reg(1'b1, v); chk(v == 0, "R1 high", v, 0);
    read_reg(1'b0, v); chk(v == 0, "R1 low", v, 0);

    // R9 read held through a computation: unsigned multiply 5*3
    @(negedge clk);
    start = 1'b1; op = 2'd1; opnd_a = 4'd5; opnd_b = 4'd3;
    @(negedge clk);
    start = 1'b0; rd_req = 1'b1; rd_sel = 1'b0;
    bc = 0;
    while (busy && bc < 4*BW) begin
      chk(rd_ready == 1'b0, "R9 stall", rd_ready, 0);
      chk(rd_data == '0, "R9 hold", rd_data, 0);
      bc++;
      @(negedge clk);
    end
    chk(bc == BW, "R6 busy length", bc, BW);
    chk(rd_ready == 1'b1, "R9 ready after busy", rd_ready, 1);
    @(negedge clk); rd_req = 1'b0;
    chk(rd_data == 4'd15, "R9 read low", rd_data, 15);
    read_reg(1'b1, v); chk(v == 0, "R9 read high", v, 0);

    // Exhaustive sweep over all codes and operand pairs
    for (int o = 0; o < 4; o++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          run_op(o, a, b, 1'b0, bc);
          if (o >= 2 && b == 0) begin
            chk(bc == BW, "R8 divide by zero completes", bc, BW);
            chk(busy == 1'b0, "R8 idle after zero divisor", busy, 0);
          end else begin
            chk(bc == BW, "R6 busy length", bc, BW);
            model(o, a, b, eh, el);
            read_reg(1'b1, h);
            read_reg(1'b0, l);
            case (o)
              0: begin chk(h == eh, "R2 high", h, eh); chk(l == el, "R2 low", l, el); end
              1: begin chk(h == eh, "R3 high", h, eh); chk(l == el, "R3 low", l, el); end
              2: begin chk(h == eh, "R4 remainder", h, eh); chk(l == el, "R4 quotient", l, el); end
              default: begin chk(h == eh, "R5 remainder", h, eh); chk(l == el, "R5 quotient", l, el); end
            endcase
          end
        end
      end
    end

    // R7 start while busy is ignored
    run_op(1, 7, 9, 1'b1, bc);
    chk(bc == BW, "R7 duration", bc, BW);
    read_reg(1'b1, h); chk(h == 3, "R7 high", h, 3);
    read_reg(1'b0, l); chk(l == 15, "R7 low", l, 15);
    run_op(2, 9, 3, 1'b1, bc);
    model(2, 9, 3, eh, el);
    chk(bc == BW, "R7 duration div", bc, BW);
    read_reg(1'b1, h); chk(h == eh, "R7 div remainder", h, eh);
    read_reg(1'b0, l); chk(l == el, "R7 div quotient", l, el);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule